// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A character is handed over through a valid/ready pair. The line then carries a 0 start bit, the data bits least-significant first, an optional parity bit, and one or two 1 stop bits. The line rests at 1 when idle. Bit timing comes from an external baud generator, which pulses `bit_tick` for one clock cycle at each bit boundary. Every bit on the line lasts exactly one tick interval.

The frame format is chosen at run time by four level inputs: word size (7 or 8 data bits), parity on/off, odd/even parity sense, and one or two stop bits. These inputs are captured when a character is accepted, so they may be changed freely between characters or during a frame.

Dropping the transmit enable aborts a frame in progress at once and returns the line to mark. While the enable is low, no character is accepted. A one-cycle synchronous clear pulse also returns the transmitter to idle.

Top module: `sertx_core`

## Requirements
- R1: After reset, and whenever the transmitter is idle, `txd` is 1 and `busy` is 0. `chr_ready` is high exactly when the transmitter is idle, `tx_en` is 1 and `sync_clr` is 0.
- R2: A frame begins with one 0 start bit. The data bits follow, least significant bit first. Each bit on the line lasts exactly one `bit_tick` interval, and the start bit begins at the tick after acceptance.
- R3: With `cfg_wide` = 1, eight data bits (bits 0 to 7) are sent. With `cfg_wide` = 0, only bits 0 to 6 are sent; bit 7 is not transmitted and does not enter the parity sum.
- R4: With `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_en` = 0, no parity bit is sent and `cfg_par_odd` has no effect.
- R5: With `cfg_par_odd` = 1, the sent data bits plus the parity bit hold an odd number of 1s. With `cfg_par_odd` = 0, they hold an even number of 1s.
- R6: With `cfg_two_stop` = 1, two 1 stop bits end the frame. With `cfg_two_stop` = 0, one 1 stop bit ends the frame.
- R7: The four format inputs and the character are sampled in the accepting cycle. Changing them afterwards does not alter the frame in progress.
- R8: `busy` rises in the cycle after acceptance and stays high through the last stop bit. It falls at the tick that ends the last stop bit.
- R9: If `tx_en` is 0 while `busy` is high, then in the next cycle `busy` is 0 and `txd` is 1. The partial frame is not resumed.
- R10: While `tx_en` is 0, `chr_ready` is 0 and `chr_valid` is ignored: no frame starts and `txd` stays 1.
- R11: A one-cycle `sync_clr` pulse makes `busy` 0 and `txd` 1 in the next cycle.
- R12: A character is accepted only in a cycle with `chr_valid` and `chr_ready` both high. `chr_ready` stays low while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous clear pulse, returns to idle |
| tx_en | input | 1 | Transmit enable; low aborts and blocks loading |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| chr_data | input | DATA_W | Character to send |
| chr_valid | input | 1 | Character offered |
| chr_ready | output | 1 | Character can be accepted this cycle |
| cfg_wide | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 data bits |
| cfg_par_en | input | 1 | Parity bit appended when 1 |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The properties assume that `bit_tick` is a single-cycle pulse. They also assume that `tx_en` and `sync_clr` are the only causes of an early return to idle. Under these assumptions the line holds still between ticks, and `busy` can fall only on a tick, on an abort or on a clear. The stimulus drives every input on the falling clock edge. It pulses the tick for one cycle in every four, holds `chr_valid` for only one cycle per character, and inverts the character and all format inputs right after acceptance to show that they were captured.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_PAR   = 3'd4,
        ST_STOP  = 3'd5
    } tx_state_e;

    typedef struct packed {
        logic wide;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } tx_fmt_t;

endpackage

// File: rtl/sertx_par.sv
module sertx_par #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    input  logic         odd,
    output logic         bit_o
);
    // Even sense: the parity bit equals the XOR of the data, so the total count of 1s is even.
    assign bit_o = (^vec) ^ odd;
endmodule

// File: rtl/sertx_ctl.sv
module sertx_ctl
    import sertx_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             tx_en,
    input  logic             bit_tick,
    input  logic             chr_valid,
    input  tx_fmt_t          fmt_in,
    output logic             chr_ready,
    output logic             load,
    output logic             busy,
    output tx_state_e        nxt_state,
    output logic [IDX_W-1:0] nxt_idx
);
    localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(DATA_W - 2);

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] idx;
        logic             stop_more;
        tx_fmt_t          fmt;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, idx: '0, stop_more: 1'b0, fmt: '0};

    ctl_t             r_d, r_q;
    logic             ready_c;
    logic             load_c;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        r_d      = r_q;
        load_c   = 1'b0;
        ready_c  = tx_en && !sync_clr && (r_q.st == ST_IDLE);
        last_idx = r_q.fmt.wide ? LAST_WIDE : LAST_NARROW;

        if (sync_clr || (!tx_en && r_q.st != ST_IDLE)) begin
            r_d.st        = ST_IDLE;
            r_d.idx       = '0;
            r_d.stop_more = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (chr_valid && ready_c) begin
                        load_c        = 1'b1;
                        r_d.st        = ST_ARM;
                        r_d.fmt       = fmt_in;
                        r_d.idx       = '0;
                        r_d.stop_more = fmt_in.two_stop;
                    end
                end
                ST_ARM: begin
                    if (bit_tick) r_d.st = ST_START;
                end
                ST_START: begin
                    if (bit_tick) begin
                        r_d.st  = ST_DATA;
                        r_d.idx = '0;
                    end
                end
                ST_DATA: begin
                    if (bit_tick) begin
                        if (r_q.idx == last_idx) begin
                            r_d.st = r_q.fmt.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_tick) r_d.st = ST_STOP;
                end
                ST_STOP: begin
                    if (bit_tick) begin
                        if (r_q.stop_more) r_d.stop_more = 1'b0;
                        else               r_d.st        = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign chr_ready = ready_c;
    assign load      = load_c;
    assign busy      = (r_q.st != ST_IDLE);
    assign nxt_state = r_d.st;
    assign nxt_idx   = r_d.idx;
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
    import sertx_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] chr_data,
    input  tx_fmt_t           fmt_in,
    input  tx_state_e         nxt_state,
    input  logic [IDX_W-1:0]  nxt_idx,
    output logic              txd
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
        logic              txd;
    } dp_t;

    localparam dp_t DP_RST = '{data: '0, par: 1'b0, txd: 1'b1};

    dp_t               r_d, r_q;
    logic [DATA_W-1:0] masked;
    logic              par_c;

    // Narrow words drop the top bit before it reaches the shift data or the parity sum.
    always_comb begin
        masked = chr_data;
        if (!fmt_in.wide) masked[DATA_W-1] = 1'b0;
    end

    sertx_par #(.W(DATA_W)) par_i (
        .vec   (masked),
        .odd   (fmt_in.par_odd),
        .bit_o (par_c)
    );

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.data = masked;
            r_d.par  = par_c;
        end
        unique case (nxt_state)
            ST_START: r_d.txd = 1'b0;
            ST_DATA:  r_d.txd = r_q.data[nxt_idx];
            ST_PAR:   r_d.txd = r_q.par;
            default:  r_d.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= DP_RST;
        else        r_q <= r_d;
    end

    assign txd = r_q.txd;
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_valid,
    output logic              chr_ready,
    input  logic              cfg_wide,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              txd,
    output logic              busy
);
    tx_fmt_t          fmt_in;
    tx_state_e        nxt_state;
    logic [IDX_W-1:0] nxt_idx;
    logic             load;

    assign fmt_in = '{wide: cfg_wide, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    sertx_ctl #(.DATA_W(DATA_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_clr  (sync_clr),
        .tx_en     (tx_en),
        .bit_tick  (bit_tick),
        .chr_valid (chr_valid),
        .fmt_in    (fmt_in),
        .chr_ready (chr_ready),
        .load      (load),
        .busy      (busy),
        .nxt_state (nxt_state),
        .nxt_idx   (nxt_idx)
    );

    sertx_dp #(.DATA_W(DATA_W)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .chr_data  (chr_data),
        .fmt_in    (fmt_in),
        .nxt_state (nxt_state),
        .nxt_idx   (nxt_idx),
        .txd       (txd)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_clr,
    input logic tx_en,
    input logic bit_tick,
    input logic chr_valid,
    input logic chr_ready,
    input logic txd,
    input logic busy
);
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r10_no_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !chr_ready);

    a_r12_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chr_ready |-> !busy);

    a_r12_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && chr_ready) |=> busy);

    a_r9_abort_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_en) |=> (!busy && txd));

    a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (!busy && txd));

    a_r2_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick && tx_en && !sync_clr) |=> $stable(txd));

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick && tx_en && !sync_clr) |=> busy);
endmodule

bind sertx_core sertx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .tx_en     (tx_en),
    .bit_tick  (bit_tick),
    .chr_valid (chr_valid),
    .chr_ready (chr_ready),
    .txd       (txd),
    .busy      (busy)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, sync_clr, tx_en, bit_tick, chr_valid;
    logic       cfg_wide, cfg_par_en, cfg_par_odd, cfg_two_stop;
    logic [7:0] chr_data;
    logic       chr_ready, txd, busy;
    int         n_vec = 0;
    int         n_bad = 0;
    int         tick_ph = 0;

    always #4 clk = ~clk;

    sertx_core #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .tx_en(tx_en),
        .bit_tick(bit_tick), .chr_data(chr_data), .chr_valid(chr_valid),
        .chr_ready(chr_ready), .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .txd(txd), .busy(busy)
    );

    // One-cycle tick every four clocks
    always @(negedge clk) begin
        tick_ph  = (tick_ph == 3) ? 0 : tick_ph + 1;
        bit_tick = (tick_ph == 0);
    end

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_fmt(input logic [3:0] f);
        {cfg_wide, cfg_par_en, cfg_par_odd, cfg_two_stop} = f;
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic offer(input logic [7:0] d, input logic [3:0] f);
        @(negedge clk);
        while (!chr_ready) @(negedge clk);
        chr_data  = d;
        set_fmt(f);
        chr_valid = 1'b1;
        @(negedge clk);
        chr_valid = 1'b0;
        chr_data  = ~d;
        set_fmt(~f);   // R7: disturb every format input after capture
    endtask

    // f = {wide, par_en, par_odd, two_stop}
    task automatic send_frame(input logic [7:0] d, input logic [3:0] f);
        logic [7:0]  dm;
        logic [12:0] e, g, m;
        int          n, w;
        bit          seen;
        offer(d, f);
        check(busy === 1'b1 && chr_ready === 1'b0, "R8 R12 busy after accept",
              {14'd0, busy, chr_ready}, 16'h0002);
        w  = f[3] ? 8 : 7;
        dm = f[3] ? d : {1'b0, d[6:0]};
        e  = '1;
        e[0] = 1'b0;
        for (int i = 0; i < w; i++) e[1+i] = dm[i];
        n = 1 + w;
        if (f[2]) begin
            e[n] = f[1] ? ~^dm : ^dm;
            n++;
        end
        n = n + (f[0] ? 2 : 1);
        m = 13'((14'd1 << n) - 1);
        wait_start(seen);
        check(seen, "R2 start bit seen", {15'd0, seen}, 16'h0001);
        if (seen) begin
            g = '0;
            @(negedge clk);
            g[0] = txd;
            for (int i = 1; i < n; i++) begin
                repeat (4) @(negedge clk);
                g[i] = txd;
            end
            check((g & m) == (e & m), "R2 R3 R4 R5 R6 R7 frame bits",
                  {3'd0, g & m}, {3'd0, e & m});
            repeat (2) @(negedge clk);
            check(busy === 1'b1, "R8 busy through last stop", {15'd0, busy}, 16'h0001);
            @(negedge clk);
            check(busy === 1'b0 && txd === 1'b1, "R8 R6 idle after last stop",
                  {14'd0, busy, txd}, 16'h0001);
        end
    endtask

    function automatic logic [7:0] pattern(input int f, input int p);
        case (p)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h5A;
            4: return 8'h80;
            5: return 8'h7F;
            default: return 8'(f * 37 + 29);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        bit ok;
        rst_n = 1'b0; sync_clr = 1'b0; tx_en = 1'b1; chr_valid = 1'b0;
        chr_data = '0; set_fmt(4'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0 && chr_ready === 1'b1, "R1 reset state",
              {13'd0, txd, busy, chr_ready}, 16'h0005);

        // Every format against several characters
        for (int f = 0; f < 16; f++)
            for (int p = 0; p < 7; p++)
                send_frame(pattern(f, p), 4'(f));

        // R9 / R10: abort in mid data, then offers while disabled
        offer(8'h3C, 4'b1111);
        wait_start(seen);
        repeat (6) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(!busy && txd && !chr_ready, "R9 R10 abort to mark",
              {13'd0, busy, txd, chr_ready}, 16'h0002);
        chr_valid = 1'b1;
        ok = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (busy || !txd || chr_ready) ok = 1'b0;
        end
        check(ok, "R10 valid ignored while disabled", {15'd0, ok}, 16'h0001);
        chr_valid = 1'b0;
        tx_en = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && txd === 1'b1, "R10 nothing captured",
              {14'd0, busy, txd}, 16'h0001);
        send_frame(8'hC3, 4'b1010);   // R9: clean restart after abort

        // R11: synchronous clear in mid frame
        offer(8'h96, 4'b1100);
        wait_start(seen);
        repeat (9) @(negedge clk);
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        check(busy === 1'b0 && txd === 1'b1, "R11 clear to idle",
              {14'd0, busy, txd}, 16'h0001);
        send_frame(8'h4B, 4'b0111);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule